// File: doc/BRIEF.md
# Signed Power-of-Two Divider with Selectable Rounding

This block divides a signed two's-complement integer by 2^k using only an adder and an arithmetic right shift. Three rounding behaviours can be chosen per operation: toward negative infinity, toward positive infinity, and to the nearest integer with exact halves pushed away from zero. It is intended for rescaling fixed-point products and accumulators, where a plain arithmetic shift would always round toward negative infinity and bias negative results.

The block is purely combinational. A rounding bias is chosen from the mode, the sign of the operand and k. It is added at one bit wider than the operand, and the widened sum is then shifted arithmetically. The quotient has the same width as the operand. A parameter selects the shifter: either a logarithmic chain of conditional stages or a single shift operator.

Top module: `pow2div`

## Requirements
- R1: With mode 2'b00 the result equals floor(value / 2^k). Vacated upper bits take the operand's sign, so that for example -1 divided by 16 gives -1 and not a large positive value.
- R2: With mode 2'b01 the result equals ceiling(value / 2^k).
- R3: With mode 2'b10 the result is value / 2^k rounded to the nearest integer. A remainder of exactly half moves the result away from zero, so that -1.5 gives -2 and +1.5 gives +2.
- R4: Mode 2'b11 gives the same result as mode 2'b00 for every operand and k.
- R5: When k is 0 the result equals the operand in every mode.
- R6: No mode overflows at the ends of the operand range. For example, with a 16-bit operand, 32767 rounded up by k=1 gives 16384, -32768 rounded to nearest by k=1 gives -16384, and 32767 rounded to nearest by k=15 gives 1. A non-negative operand never yields a negative result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| value_i | input | W (16) | Signed dividend |
| shift_i | input | KW (4) | Exponent k of the divisor 2^k, 0 to W-1 |
| mode_i | input | 2 | Rounding select: 00 floor, 01 ceiling, 10 nearest, 11 floor |
| result_o | output | W (16) | Signed quotient |

## Verification
The hardest case to reach is a remainder of exactly half the divisor on a negative operand, combined with the largest shift or an operand at the end of the range. In that case a one-off error in the bias, or a bias added at the operand's own width, still gives plausible results everywhere else. The stimulus table therefore places operands such as -16384 with k=15 and -32768 with k=1 directly. A sweep then applies every k from 0 to 15 to operands that sit one below, on, and one above each half-divisor point, in all four modes, and compares each result against a reference computed from integer division and remainder.

// File: rtl/pow2div_pkg.sv
package pow2div_pkg;
   typedef enum logic [1:0] {
      RND_FLOOR = 2'b00,
      RND_CEIL  = 2'b01,
      RND_NEAR  = 2'b10,
      RND_SPARE = 2'b11
   } rnd_mode_e;
endpackage

// File: rtl/pow2div_bias.sv
module pow2div_bias
   import pow2div_pkg::*;
#(
   parameter int W  = 16,
   parameter int KW = 4
) (
   input  logic [KW-1:0] k_i,
   input  logic          neg_i,
   input  rnd_mode_e     mode_i,
   output logic [W:0]    bias_o
);
   logic [31:0] k_wide;
   logic [W:0]  ones;
   logic [W:0]  below_half;
   logic [W:0]  half;

   assign k_wide = 32'(k_i);

   // ones has the low k bits set: the value 2^k - 1
   for (genvar g = 0; g <= W; g++) begin : g_mask
      assign ones[g] = (k_wide > 32'(g));
   end

   assign below_half = {1'b0, ones[W:1]};
   assign half       = ones ^ below_half;

   always_comb begin
      unique case (mode_i)
         RND_CEIL:  bias_o = ones;
         RND_NEAR:  bias_o = neg_i ? below_half : half;
         default:   bias_o = '0;
      endcase
   end
endmodule

// File: rtl/pow2div_ashift.sv
module pow2div_ashift #(
   parameter int WD     = 17,
   parameter int KW     = 4,
   parameter bit STAGED = 1'b1
) (
   input  logic [WD-1:0] in_i,
   input  logic [KW-1:0] k_i,
   output logic [WD-1:0] out_o
);
   if (STAGED) begin : g_staged
      logic [WD-1:0] stage [KW+1];
      assign stage[0] = in_i;
      for (genvar s = 0; s < KW; s++) begin : g_stage
         localparam int SH = 1 << s;
         if (SH < WD) begin : g_fit
            assign stage[s+1] = k_i[s]
               ? {{SH{stage[s][WD-1]}}, stage[s][WD-1:SH]}
               : stage[s];
         end else begin : g_wide
            assign stage[s+1] = k_i[s] ? {WD{stage[s][WD-1]}} : stage[s];
         end
      end
      assign out_o = stage[KW];
   end else begin : g_operator
      assign out_o = $unsigned($signed(in_i) >>> k_i);
   end
endmodule

// File: rtl/pow2div.sv
module pow2div
   import pow2div_pkg::*;
#(
   parameter int W      = 16,
   parameter int KW     = $clog2(W),
   parameter bit STAGED = 1'b1
) (
   input  logic signed [W-1:0]  value_i,
   input  logic        [KW-1:0] shift_i,
   input  logic        [1:0]    mode_i,
   output logic signed [W-1:0]  result_o
);
   localparam int WD   = W + 1;
   localparam int KMAX = W - 1;

   if (W < 2) begin : g_bad_width
      $error("pow2div: W must be at least 2");
   end
   if (KW != $clog2(W)) begin : g_bad_kw
      $error("pow2div: KW must equal clog2(W)");
   end

   rnd_mode_e      mode;
   logic [KW-1:0]  k_eff;
   logic [W:0]     bias;
   logic [WD-1:0]  ext;
   logic [WD-1:0]  sum;
   logic [WD-1:0]  shifted;

   assign mode  = rnd_mode_e'(mode_i);
   // shifts beyond W-1 (only reachable when W is not a power of two) clamp
   assign k_eff = (32'(shift_i) > 32'(KMAX)) ? KW'(KMAX) : shift_i;

   pow2div_bias #(.W(W), .KW(KW)) u_bias (
      .k_i    (k_eff),
      .neg_i  (value_i[W-1]),
      .mode_i (mode),
      .bias_o (bias)
   );

   assign ext = {value_i[W-1], value_i};
   assign sum = ext + bias;

   pow2div_ashift #(.WD(WD), .KW(KW), .STAGED(STAGED)) u_shift (
      .in_i  (sum),
      .k_i   (k_eff),
      .out_o (shifted)
   );

   assign result_o = $signed(shifted[W-1:0]);
endmodule

// File: rtl/pow2div_chk.sv
module pow2div_chk #(
   parameter int W  = 16,
   parameter int KW = 4
) (
   input logic signed [W-1:0]  value_i,
   input logic        [KW-1:0] shift_i,
   input logic        [1:0]    mode_i,
   input logic signed [W-1:0]  result_o
);
   logic signed [63:0] xv, qv, dv, qd, err2, aerr2, aqd, ax;
   logic               k_ok;

   always_comb begin
      xv    = 64'(value_i);
      qv    = 64'(result_o);
      dv    = 64'sd1 <<< shift_i;
      qd    = qv * dv;
      err2  = 2 * xv - 2 * qd;
      aerr2 = (err2 < 0) ? -err2 : err2;
      aqd   = (qd < 0) ? -qd : qd;
      ax    = (xv < 0) ? -xv : xv;
      k_ok  = (32'(shift_i) < W);
   end

   always_comb begin
      if (k_ok && mode_i == 2'b00) begin
         p_floor_bound_r1: assert (qd <= xv && xv < qd + dv)
            else $error("floor bound violated");
      end
      if (k_ok && mode_i == 2'b01) begin
         p_ceil_bound_r2: assert (qd - dv < xv && xv <= qd)
            else $error("ceiling bound violated");
      end
      if (k_ok && mode_i == 2'b10) begin
         p_near_bound_r3: assert (aerr2 <= dv && (aerr2 != dv || aqd > ax))
            else $error("nearest bound violated");
      end
      if (k_ok && mode_i == 2'b11) begin
         p_spare_floor_r4: assert (qd <= xv && xv < qd + dv)
            else $error("spare mode not floor");
      end
      if (shift_i == '0) begin
         p_identity_r5: assert (result_o == value_i)
            else $error("k=0 changed value");
      end
      if (!value_i[W-1]) begin
         p_no_overflow_r6: assert (!result_o[W-1])
            else $error("non-negative operand gave negative result");
      end
   end
endmodule

bind pow2div pow2div_chk #(.W(W), .KW(KW)) u_chk (
   .value_i  (value_i),
   .shift_i  (shift_i),
   .mode_i   (mode_i),
   .result_o (result_o)
);

// File: tb/sim_pow2div.sv
module sim_pow2div;
   localparam int W  = 16;
   localparam int KW = 4;
   localparam int NV = 26;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic signed [W-1:0]  value;
   logic        [KW-1:0] shift;
   logic        [1:0]    mode;
   logic signed [W-1:0]  result;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pow2div #(.W(W), .KW(KW)) u0 (
      .value_i  (value),
      .shift_i  (shift),
      .mode_i   (mode),
      .result_o (result)
   );

   // {operand[15:0], k[3:0], mode[1:0], expected[15:0]}
   localparam logic [37:0] VEC [NV] = '{
      {16'hFFF9, 4'd2,  2'b00, 16'hFFFE},   // R1 -1.75 -> -2
      {16'hFFFF, 4'd4,  2'b00, 16'hFFFF},   // R1 -1/16 stays -1
      {16'h0007, 4'd2,  2'b00, 16'h0001},   // R1
      {16'hFFF9, 4'd2,  2'b01, 16'hFFFF},   // R2 -1.75 -> -1
      {16'hFFFF, 4'd4,  2'b01, 16'h0000},   // R2
      {16'h0005, 4'd2,  2'b01, 16'h0002},   // R2
      {16'hFFF9, 4'd2,  2'b10, 16'hFFFE},   // R3 -1.75 -> -2
      {16'hFFFA, 4'd2,  2'b10, 16'hFFFE},   // R3 -1.5 -> -2
      {16'h0006, 4'd2,  2'b10, 16'h0002},   // R3 +1.5 -> 2
      {16'h0005, 4'd2,  2'b10, 16'h0001},   // R3
      {16'hFFFB, 4'd2,  2'b10, 16'hFFFF},   // R3 -1.25 -> -1
      {16'hFE00, 4'd8,  2'b10, 16'hFFFE},   // R3 -2.0
      {16'hFE80, 4'd8,  2'b10, 16'hFFFE},   // R3 -1.5
      {16'h0180, 4'd8,  2'b10, 16'h0002},   // R3 +1.5
      {16'hC000, 4'd15, 2'b10, 16'hFFFF},   // R3 -0.5 -> -1
      {16'hC000, 4'd15, 2'b01, 16'h0000},   // R2 -0.5 -> 0
      {16'hFFF9, 4'd2,  2'b11, 16'hFFFE},   // R4
      {16'h0007, 4'd3,  2'b11, 16'h0000},   // R4
      {16'hFB2E, 4'd0,  2'b10, 16'hFB2E},   // R5
      {16'hFB2E, 4'd0,  2'b01, 16'hFB2E},   // R5
      {16'h7FFF, 4'd1,  2'b01, 16'h4000},   // R6
      {16'h7FFF, 4'd1,  2'b10, 16'h4000},   // R6
      {16'h8000, 4'd15, 2'b01, 16'hFFFF},   // R6
      {16'h8000, 4'd1,  2'b10, 16'hC000},   // R6
      {16'h7FFF, 4'd15, 2'b10, 16'h0001},   // R6
      {16'h7FFF, 4'd15, 2'b00, 16'h0000}    // R6
   };

   function automatic logic [W-1:0] model(int x, int k, int m);
      int d, q, r, ar;
      d  = 1 << k;
      q  = x / d;
      r  = x % d;
      ar = (r < 0) ? -r : r;
      case (m)
         1: if (r > 0) q = q + 1;
         2: if (2 * ar >= d) q = (x < 0) ? q - 1 : q + 1;
         default: if (r < 0) q = q - 1;
      endcase
      return q[W-1:0];
   endfunction

   task automatic apply(input string req, input logic [W-1:0] x,
                        input logic [KW-1:0] k, input logic [1:0] m,
                        input logic [W-1:0] exp);
      @(posedge clk);
      #1;
      value = x;
      shift = k;
      mode  = m;
      @(negedge clk);
      nvec++;
      if (result !== exp) begin
         nbad++;
         $display("FAIL %s: x=%0d k=%0d m=%0d actual=%h expected=%h",
                  req, $signed(x), k, m, result, exp);
      end
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      value = '0;
      shift = '0;
      mode  = 2'b00;
      repeat (3) @(posedge clk);
      // reset state: zero operand yields zero (R1)
      @(negedge clk);
      nvec++;
      if (result !== '0) begin
         nbad++;
         $display("FAIL R1 reset: actual=%h expected=0000", result);
      end
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         logic [37:0] v;
         string tag;
         v = VEC[i];
         case (v[17:16])
            2'b00: tag = "R1";
            2'b01: tag = "R2";
            2'b10: tag = "R3";
            default: tag = "R4";
         endcase
         if (v[21:18] == 4'd0) tag = "R5";
         if (v[37:22] == 16'h7FFF || v[37:22] == 16'h8000) tag = "R6";
         apply(tag, v[37:22], v[21:18], v[17:16], v[15:0]);
      end

      // sweep: every k, operands around half-divisor points, all modes
      for (int k = 0; k < W; k++) begin
         for (int p = 0; p < 12; p++) begin
            int h, x;
            h = (k == 0) ? 0 : (1 << (k - 1));
            case (p)
               0: x = h - 1;   1: x = h;       2: x = h + 1;
               3: x = -h + 1;  4: x = -h;      5: x = -h - 1;
               6: x = 3 * h;   7: x = -3 * h;  8: x = 32767;
               9: x = -32768;  10: x = -1;     default: x = 1;
            endcase
            if (x > 32767) x = 32767;
            if (x < -32768) x = -32768;
            for (int m = 0; m < 4; m++) begin
               string tag;
               case (m)
                  0: tag = "R1";
                  1: tag = "R2";
                  2: tag = "R3";
                  default: tag = "R4";
               endcase
               if (k == 0) tag = "R5";
               apply(tag, x[W-1:0], k[KW-1:0], m[1:0], model(x, k, m));
            end
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule